// File: doc/BRIEF.md
# Clocked Non-Retriggerable One-Shot with Override Clear

This block produces a single output pulse of programmable length each time it sees a qualified trigger. It has two trigger pins: one fires on its falling edge, the other on its rising edge, and each pin's level gates the other. A falling edge on `trg_fall` counts only while `trg_rise` is high. A rising edge on `trg_rise` counts only while `trg_fall` is low. Both pins pass through a two-flop synchroniser before edge detection, so they may be driven from any clock domain.

The pulse length is a count of clock cycles taken from `width`. The count is captured when a pulse starts. Once a pulse is running, the block ignores every trigger pin movement until the pulse is over. The active-low input `rst_n` is an asynchronous override: it clears the block at any moment, including partway through a pulse.

Two instances side by side give a dual device. The trigger pins carry events, not a data stream, so no handshake is attached to them.

Top module: `os_monostable`

## Requirements
- R1: While `rst_n` is low, and after it is released with no trigger, `q` is 0 and `q_n` is 1.
- R2: A falling edge on `trg_fall` while `trg_rise` is high starts a pulse.
- R3: A rising edge on `trg_rise` while `trg_fall` is low starts a pulse.
- R4: A falling edge on `trg_fall` while `trg_rise` is low starts no pulse. A rising edge on `trg_rise` while `trg_fall` is high starts no pulse.
- R5: For a `width` of N (1 to 255), `q` goes high three rising clock edges after the trigger pin changes (two synchroniser flops plus the timer register). It then stays high for exactly N cycles.
- R6: A `width` of 0 at the moment of triggering produces no pulse.
- R7: Trigger edges that reach the timer while `q` is high are ignored, including an edge that arrives in the last high cycle. After `q` returns low, a fresh edge is needed to start another pulse.
- R8: The output length does not depend on how long the trigger pin stays in its active state, whether that is one cycle or much longer than the pulse.
- R9: Driving `rst_n` low ends a pulse at once, without waiting for a clock edge. No pulse resumes afterwards.
- R10: Edges that occur while `rst_n` is low are ignored, and releasing `rst_n` does not start a pulse. Edge detection resumes three cycles after release.
- R11: `q_n` is always the complement of `q`.
- R12: `width` is sampled only when a pulse starts. Changing it during a pulse leaves that pulse's length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous override clear |
| trg_fall | input | 1 | Trigger on falling edge; its low level enables `trg_rise` |
| trg_rise | input | 1 | Trigger on rising edge; its high level enables `trg_fall` |
| width | input | CNT_W | Pulse length in clock cycles; 0 means no pulse |
| q | output | 1 | Pulse output, high while a pulse is running |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench fires each trigger pin with its enabling level present and absent. This separates the two edge paths and shows the gating works.

Pulse widths of 0, 1, a mid value and the maximum pin down the exact latency and length. Trigger pulses of one cycle and of many cycles show that the output length does not depend on the input duration.

Second edges are placed in three positions:
- mid-pulse;
- in the exact last high cycle;
- one cycle after the pulse ends.

Together these fix the retrigger boundary to a single cycle. The clear is exercised mid-pulse, between clock edges, and with edges applied while it is held. This tells an asynchronous clear apart from a synchronous one, and shows that release does not produce a spurious edge.

// File: rtl/os_pkg.sv
`timescale 1ns/1ps
package os_pkg;
  // Smallest synchroniser depth that resolves metastability on the trigger pins.
  localparam int unsigned OS_MIN_SYNC = 2;

  // Raw qualified edge flags, one per trigger path.
  typedef struct packed {
    logic fall_seen;
    logic rise_seen;
  } os_edge_t;
endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) chain[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk) chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/os_trig.sv
`timescale 1ns/1ps
module os_trig
  import os_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = OS_MIN_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_pin,
  input  logic rise_pin,
  output logic hit
);
  // Cycles after clear release before the edge history can be trusted.
  localparam int unsigned ARM_CYCLES = SYNC_STAGES + 1;
  localparam int unsigned ARM_W      = $clog2(ARM_CYCLES + 1);

  logic             a_s, b_s, a_prev, b_prev;
  logic [ARM_W-1:0] arm_cnt;
  logic             armed;
  os_edge_t         raw;

  os_sync #(.STAGES(SYNC_STAGES)) u_sync_fall (.clk(clk), .d(fall_pin), .q(a_s));
  os_sync #(.STAGES(SYNC_STAGES)) u_sync_rise (.clk(clk), .d(rise_pin), .q(b_s));

  // The history flops keep tracking the pins during a clear, so release sees no step.
  always_ff @(posedge clk) begin
    a_prev <= a_s;
    b_prev <= b_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              arm_cnt <= '0;
    else if (arm_cnt != ARM_W'(ARM_CYCLES))  arm_cnt <= arm_cnt + 1'b1;
  end

  assign armed         = (arm_cnt == ARM_W'(ARM_CYCLES));
  assign raw.fall_seen = a_prev & ~a_s & b_s;
  assign raw.rise_seen = ~b_prev & b_s & ~a_s;
  assign hit           = armed & (|raw);
endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
module os_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle;

  assign idle = (cnt_q == '0);

  // Load only when idle: a start during a running pulse is dropped.
  always_comb begin
    cnt_d = cnt_q;
    if (idle) begin
      if (start) cnt_d = width;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pulse <= (cnt_d != '0);
    end
  end
endmodule

// File: rtl/os_monostable.sv
`timescale 1ns/1ps
module os_monostable
  import os_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = OS_MIN_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trg_fall,
  input  logic             trg_rise,
  input  logic [CNT_W-1:0] width,
  output logic             q,
  output logic             q_n
);
  logic trig_hit;
  logic pulse;

  os_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .fall_pin(trg_fall), .rise_pin(trg_rise), .hit(trig_hit)
  );

  os_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(trig_hit), .width(width), .pulse(pulse)
  );

  assign q   = pulse;
  assign q_n = ~pulse;
endmodule

// File: rtl/os_monostable_chk.sv
`timescale 1ns/1ps
module os_monostable_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] width,
  input logic             fire,
  input logic             q
);
  logic             q_d, fire_d;
  logic [CNT_W-1:0] w_d, len_r, cap_r;

  // Independent model: track the run length of q and the width seen at its start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d    <= 1'b0;
      fire_d <= 1'b0;
      w_d    <= '0;
      len_r  <= '0;
      cap_r  <= '0;
    end else begin
      q_d    <= q;
      fire_d <= fire;
      w_d    <= width;
      if (q && !q_d) begin
        len_r <= CNT_W'(1);
        cap_r <= w_d;
      end else if (q) begin
        len_r <= len_r + 1'b1;
      end
    end
  end

  AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) !rst_n |-> !q); // R9
  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !q_d) |-> fire_d); // R2
  AST_ZERO_WIDTH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !q_d) |-> (w_d != '0)); // R6
  AST_EXACT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && q_d) |-> (len_r == cap_r)); // R5
  AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (q && q_d) |-> (len_r < cap_r)); // R7
endmodule

bind os_monostable os_monostable_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .width(width), .fire(trig_hit), .q(q)
);

// File: tb/test_os_monostable.sv
`timescale 1ns/1ps
module test_os_monostable;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trg_fall = 1'b1;
  logic             trg_rise = 1'b1;
  logic [CNT_W-1:0] width = '0;
  logic             q, q_n;

  int n_checks = 0;
  int n_fail   = 0;
  int m_first, m_len, m_runs, m_highs, m_bad;

  always #2.5 clk = ~clk;  // 200 MHz

  os_monostable #(.CNT_W(CNT_W)) i_os_monostable (
    .clk(clk), .rst_n(rst_n), .trg_fall(trg_fall), .trg_rise(trg_rise),
    .width(width), .q(q), .q_n(q_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Samples q at T negedges; index 1 is the first negedge after the call.
  task automatic measure(input int t);
    bit prev = 1'b0;
    m_first = 0; m_len = 0; m_runs = 0; m_highs = 0; m_bad = 0;
    for (int i = 1; i <= t; i++) begin
      @(negedge clk);
      if (q_n !== ~q) m_bad++;
      if (q) begin
        m_highs++;
        if (!prev) begin
          m_runs++;
          if (m_runs == 1) m_first = i;
        end
        if (m_runs == 1) m_len++;
      end
      prev = q;
    end
  endtask

  // Reaches any idle level pair without producing an edge, by holding the clear.
  task automatic set_idle(input bit a, input bit b, input int w);
    @(negedge clk);
    rst_n = 1'b0;
    trg_fall = a; trg_rise = b; width = CNT_W'(w);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check(q == 1'b0 && q_n == 1'b1, "R1 during clear", q, 0);
    rst_n = 1'b1;
    measure(10);
    check(m_highs == 0, "R1 after release", m_highs, 0);
    check(m_bad == 0, "R11 complement", m_bad, 0);
  endtask

  task automatic t_fall_trigger;
    set_idle(1, 1, 7);
    fork
      measure(20);
      trg_fall = 1'b0;
    join
    check(m_first == 3, "R5 latency fall", m_first, 3);
    check(m_len == 7 && m_runs == 1, "R2 fall pulse len", m_len, 7);
    check(m_bad == 0, "R11 complement", m_bad, 0);
  endtask

  task automatic t_rise_trigger;
    set_idle(0, 0, 4);
    fork
      measure(15);
      trg_rise = 1'b1;
    join
    check(m_first == 3 && m_len == 4, "R3 rise pulse len", m_len, 4);
  endtask

  task automatic t_gating;
    set_idle(1, 0, 5);
    fork measure(15); trg_fall = 1'b0; join
    check(m_highs == 0, "R4 fall blocked by low rise pin", m_highs, 0);
    set_idle(1, 0, 5);
    fork measure(15); trg_rise = 1'b1; join
    check(m_highs == 0, "R4 rise blocked by high fall pin", m_highs, 0);
  endtask

  task automatic t_widths;
    set_idle(1, 1, 0);
    fork measure(15); trg_fall = 1'b0; join
    check(m_highs == 0, "R6 zero width", m_highs, 0);
    set_idle(1, 1, 1);
    fork measure(10); trg_fall = 1'b0; join
    check(m_first == 3 && m_len == 1, "R5 width one", m_len, 1);
    set_idle(1, 1, 255);
    fork measure(270); trg_fall = 1'b0; join
    check(m_len == 255 && m_runs == 1, "R5 width max", m_len, 255);
  endtask

  task automatic t_retrigger;
    set_idle(1, 1, 10);
    fork
      measure(30);
      begin
        trg_fall = 1'b0;
        repeat (2) @(negedge clk); trg_fall = 1'b1;
        repeat (3) @(negedge clk); trg_fall = 1'b0;
        repeat (2) @(negedge clk); trg_rise = 1'b0;
        @(negedge clk); trg_rise = 1'b1;
      end
    join
    check(m_len == 10 && m_runs == 1, "R7 mid-pulse edges ignored", m_runs, 1);
    // Edge reaching the timer in the last high cycle is dropped.
    set_idle(0, 0, 4);
    fork
      measure(20);
      begin
        trg_rise = 1'b1;
        repeat (2) @(negedge clk); trg_fall = 1'b1;
        repeat (2) @(negedge clk); trg_fall = 1'b0;
      end
    join
    check(m_runs == 1 && m_highs == 4, "R7 last-cycle edge ignored", m_highs, 4);
    // One cycle later the edge lands after the pulse and starts a new one.
    set_idle(0, 0, 4);
    fork
      measure(20);
      begin
        trg_rise = 1'b1;
        repeat (2) @(negedge clk); trg_fall = 1'b1;
        repeat (3) @(negedge clk); trg_fall = 1'b0;
      end
    join
    check(m_runs == 2 && m_highs == 8, "R7 fresh edge after end", m_runs, 2);
  endtask

  task automatic t_trigger_length;
    set_idle(1, 1, 10);
    fork
      measure(25);
      begin trg_fall = 1'b0; @(negedge clk); trg_fall = 1'b1; end
    join
    check(m_len == 10 && m_runs == 1, "R8 short trigger", m_len, 10);
    set_idle(1, 1, 5);
    fork measure(50); trg_fall = 1'b0; join
    check(m_len == 5 && m_runs == 1, "R8 long trigger", m_len, 5);
  endtask

  task automatic t_reset_abort;
    set_idle(1, 1, 20);
    trg_fall = 1'b0;
    repeat (6) @(negedge clk);
    check(q == 1'b1, "R9 pulse running before clear", q, 1);
    #1 rst_n = 1'b0;
    #1 check(q == 1'b0 && q_n == 1'b1, "R9 async end", q, 0);
    @(negedge clk); rst_n = 1'b1;
    measure(25);
    check(m_highs == 0, "R9 no resume", m_highs, 0);
  endtask

  task automatic t_reset_edges;
    set_idle(1, 1, 6);
    rst_n = 1'b0;
    @(negedge clk); trg_fall = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    measure(20);
    check(m_highs == 0, "R10 edge under clear ignored", m_highs, 0);
    trg_fall = 1'b1;
    repeat (4) @(negedge clk);
    fork measure(15); trg_fall = 1'b0; join
    check(m_len == 6, "R10 fresh edge after release", m_len, 6);
  endtask

  task automatic t_width_change;
    set_idle(1, 1, 5);
    fork
      measure(20);
      begin trg_fall = 1'b0; repeat (4) @(negedge clk); width = CNT_W'(9); end
    join
    check(m_len == 5 && m_runs == 1, "R12 width held", m_len, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_fall_trigger();
    t_rise_trigger();
    t_gating();
    t_widths();
    t_retrigger();
    t_trigger_length();
    t_reset_abort();
    t_reset_edges();
    t_width_change();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule